// File: doc/BRIEF.md
# Endpoint-Zero Control and Receive-Event Registers

This block is the register slice that a USB device controller keeps for its control endpoint (endpoint 0), together with the per-endpoint receive-complete event flags. Software reaches both registers over a simple synchronous register bus. Each access is a one-cycle strobe with a write flag, a word address and write data. Read data comes back one cycle later.

The control register shows endpoint 0 as always enabled and always of control type in both directions. Only the two stall bits can be changed. Software sets a stall bit to make that direction answer the host with a STALL handshake. The bit stays set until software clears it, or until the controller reports that a new SETUP packet has arrived. The event register has one flag per endpoint, for endpoints 0 to 3. A flag is raised when an OUT or SETUP reception completes on that endpoint, and software clears it by writing 1 to it. When the completing transfer asked for an interrupt on completion, the flag and the interrupt output rise in the same cycle. The interrupt stays high until every such flag has been cleared.

Top module: `ep0CtlRegs`

## Requirements
- R1: After reset the control register reads 0x0080_0080, the event register reads 0 and `irqOut` is low.
- R2: Control register bits 23 and 7 (the direction enables) always read 1, bits 19:18 and 3:2 (the type fields, 00 = control) always read 0, and every other bit except 16 and 0 always reads 0, whatever is written.
- R3: A write to the control register (word address 0x00) loads transmit stall from data bit 16 and receive stall from data bit 0, and the register reads those values back at the same positions.
- R4: A `setupSeen` strobe clears both stall bits at the next clock edge, and it wins over a control register write of 1 to a stall bit in the same cycle.
- R5: A `rxDone[e]` pulse sets bit e of the event register (word address 0x04), with bit e belonging to endpoint e. Event register bits 31:4 always read 0.
- R6: Writing 1 to an event bit clears it. Writing 0 to it, or writing to the reserved bits, leaves it unchanged.
- R7: When `rxDone[e]` and a write-1-to-clear of bit e fall in the same cycle, the bit ends up set.
- R8: `irqOut` rises in the same cycle that an event bit becomes visible if that completion had `rxIoc[e]` high. It stays high while any such bit remains uncleared. A completion without `rxIoc` sets its bit but does not raise `irqOut`.
- R9: `busRdata` carries the addressed register in the cycle after a read strobe and is 0 in every other cycle. Unmapped addresses read 0 and writes to them change nothing. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read (qualified by busSel) |
| busAddr | input | 8 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read strobe |
| setupSeen | input | 1 | Strobe: new SETUP packet received on endpoint 0 |
| rxDone | input | 4 | Per-endpoint receive-complete strobes |
| rxIoc | input | 4 | Interrupt-on-complete flag for the completion in the same cycle |
| irqOut | output | 1 | Level interrupt for pending interrupt-requesting completions |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. In one, a hardware completion and a software clear hit the same event bit. In the other, a SETUP strobe meets a software write that sets a stall bit. Each needs a bus write and a controller strobe to land on the same clock edge. The bench drives both from a single negative-edge slot to create them. It then sweeps all 256 combinations of completion mask and interrupt-on-complete mask. For each combination it clears the flags one at a time and recomputes the expected interrupt level arithmetically after every clear.

// File: rtl/ep0RegsPkg.sv
package ep0RegsPkg;
  localparam int DATA_W       = 32;
  localparam int TX_EN_BIT    = 23;
  localparam int TX_TYPE_LO   = 18;
  localparam int TX_STALL_BIT = 16;
  localparam int RX_EN_BIT    = 7;
  localparam int RX_TYPE_LO   = 2;
  localparam int RX_STALL_BIT = 0;
  localparam logic [1:0] EP_TYPE_CONTROL = 2'b00;

  typedef struct packed {
    logic ctlWr;
    logic evtWr;
    logic ctlRd;
    logic evtRd;
  } regStrobe_t;
endpackage

// File: rtl/ep0RegsDecode.sv
module ep0RegsDecode
  import ep0RegsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h04
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  logic hitCtl;
  logic hitEvt;

  assign hitCtl = (busAddr == CTL_ADDR);
  assign hitEvt = (busAddr == EVT_ADDR);

  always_comb begin
    strobe       = '0;
    strobe.ctlWr = busSel &  busWrite & hitCtl;
    strobe.evtWr = busSel &  busWrite & hitEvt;
    strobe.ctlRd = busSel & ~busWrite & hitCtl;
    strobe.evtRd = busSel & ~busWrite & hitEvt;
  end
endmodule

// File: rtl/ep0RegsStore.sv
module ep0RegsStore
  import ep0RegsPkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              wrTxStall,
  input  logic              wrRxStall,
  input  logic [NUM_EP-1:0] wrEvtClr,
  input  logic              setupSeen,
  input  logic [NUM_EP-1:0] rxDone,
  input  logic [NUM_EP-1:0] rxIoc,
  output logic [DATA_W-1:0] rdData,
  output logic              txStall,
  output logic              rxStall,
  output logic [NUM_EP-1:0] evtQ,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - NUM_EP;

  logic [NUM_EP-1:0] iocQ;
  logic [DATA_W-1:0] ctlView;
  logic [DATA_W-1:0] evtView;
  logic [DATA_W-1:0] rdNext;

  // Stall bits: the SETUP clear takes priority over a software write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStall <= 1'b0;
      rxStall <= 1'b0;
    end else if (setupSeen) begin
      txStall <= 1'b0;
      rxStall <= 1'b0;
    end else if (strobe.ctlWr) begin
      txStall <= wrTxStall;
      rxStall <= wrRxStall;
    end
  end

  // One event cell per endpoint: a hardware set wins over a software clear.
  for (genvar e = 0; e < NUM_EP; e++) begin : gEvt
    logic bitQ;
    logic iocBitQ;
    logic clrHit;

    assign clrHit = strobe.evtWr & wrEvtClr[e];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ    <= 1'b0;
        iocBitQ <= 1'b0;
      end else if (rxDone[e]) begin
        bitQ    <= 1'b1;
        iocBitQ <= rxIoc[e] | (iocBitQ & ~clrHit);
      end else if (clrHit) begin
        bitQ    <= 1'b0;
        iocBitQ <= 1'b0;
      end
    end

    assign evtQ[e] = bitQ;
    assign iocQ[e] = iocBitQ;
  end

  assign irqOut = |(evtQ & iocQ);

  always_comb begin
    ctlView = '0;
    ctlView[TX_EN_BIT]          = 1'b1;
    ctlView[TX_TYPE_LO +: 2]    = EP_TYPE_CONTROL;
    ctlView[TX_STALL_BIT]       = txStall;
    ctlView[RX_EN_BIT]          = 1'b1;
    ctlView[RX_TYPE_LO +: 2]    = EP_TYPE_CONTROL;
    ctlView[RX_STALL_BIT]       = rxStall;
  end

  assign evtView = {{PAD_W{1'b0}}, evtQ};

  always_comb begin
    rdNext = '0;
    if (strobe.ctlRd)      rdNext = ctlView;
    else if (strobe.evtRd) rdNext = evtView;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/ep0CtlRegs.sv
module ep0CtlRegs
  import ep0RegsPkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              setupSeen,
  input  logic [NUM_EP-1:0] rxDone,
  input  logic [NUM_EP-1:0] rxIoc,
  output logic              irqOut
);
  regStrobe_t        strobe;
  logic              txStallQ;
  logic              rxStallQ;
  logic [NUM_EP-1:0] evtQ;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata;

  ep0RegsDecode #(
    .ADDR_W  (ADDR_W),
    .CTL_ADDR(CTL_ADDR),
    .EVT_ADDR(EVT_ADDR)
  ) decode_i (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  ep0RegsStore #(
    .NUM_EP(NUM_EP)
  ) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrTxStall(busWdata[TX_STALL_BIT]),
    .wrRxStall(busWdata[RX_STALL_BIT]),
    .wrEvtClr (busWdata[NUM_EP-1:0]),
    .setupSeen(setupSeen),
    .rxDone   (rxDone),
    .rxIoc    (rxIoc),
    .rdData   (busRdata),
    .txStall  (txStallQ),
    .rxStall  (rxStallQ),
    .evtQ     (evtQ),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/ep0CtlRegsChk.sv
module ep0CtlRegsChk #(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 8'h04
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              setupSeen,
  input logic [NUM_EP-1:0] rxDone,
  input logic [NUM_EP-1:0] rxIoc,
  input logic              irqOut,
  input logic              txStall,
  input logic              rxStall,
  input logic [NUM_EP-1:0] evtQ
);
  logic ctlWrite;
  logic evtWrite;
  logic ctlRead;
  logic evtRead;
  logic unusedChk;

  assign ctlWrite  = busSel &  busWrite & (busAddr == CTL_ADDR);
  assign evtWrite  = busSel &  busWrite & (busAddr == EVT_ADDR);
  assign ctlRead   = busSel & ~busWrite & (busAddr == CTL_ADDR);
  assign evtRead   = busSel & ~busWrite & (busAddr == EVT_ADDR);
  assign unusedChk = ^busWdata;

  assert_ctl_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlRead |=> (busRdata[23] && busRdata[7] && busRdata[19:18] == 2'b00 && busRdata[3:2] == 2'b00));

  assert_stall_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && !setupSeen) |=> (txStall == $past(busWdata[16]) && rxStall == $past(busWdata[0])));

  assert_setup_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    setupSeen |=> (!txStall && !rxStall));

  assert_evt_pad_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtRead |=> (busRdata[31:NUM_EP] == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtWrite && rxDone == '0) |=> ((evtQ & $past(busWdata[NUM_EP-1:0])) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone != '0) |=> ((evtQ & $past(rxDone)) == $past(rxDone)));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((rxDone & rxIoc) != '0) |=> irqOut);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> (busRdata == '0));
endmodule

bind ep0CtlRegs ep0CtlRegsChk #(
  .NUM_EP  (NUM_EP),
  .ADDR_W  (ADDR_W),
  .CTL_ADDR(CTL_ADDR),
  .EVT_ADDR(EVT_ADDR)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .setupSeen(setupSeen),
  .rxDone   (rxDone),
  .rxIoc    (rxIoc),
  .irqOut   (irqOut),
  .txStall  (txStallQ),
  .rxStall  (rxStallQ),
  .evtQ     (evtQ)
);

// File: tb/ep0CtlRegs_tb_top.sv
`timescale 1ns/1ps
module ep0CtlRegs_tb_top;
  localparam logic [7:0] CTL_A = 8'h00;
  localparam logic [7:0] EVT_A = 8'h04;
  localparam logic [7:0] BAD_A = 8'h08;
  localparam logic [31:0] CTL_BASE = 32'h0080_0080;

  logic clk = 1'b0;
  logic rstN;
  logic busSel, busWrite, setupSeen;
  logic [7:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic [3:0]  rxDone, rxIoc;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ep0CtlRegs dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .setupSeen(setupSeen), .rxDone(rxDone), .rxIoc(rxIoc), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulseRx(input logic [3:0] done, input logic [3:0] ioc);
    rxDone = done; rxIoc = ioc;
    @(negedge clk);
    rxDone = '0; rxIoc = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic [3:0] rem;
    rstN = 1'b0; busSel = 0; busWrite = 0; busAddr = '0; busWdata = '0;
    setupSeen = 0; rxDone = '0; rxIoc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    doRead(CTL_A, rd); check("R1 ctl", rd, CTL_BASE);
    doRead(EVT_A, rd); check("R1 evt", rd, 32'h0);
    check("R9 idle", busRdata, 32'h0);

    // R2 / R3 sweep over stall values with reserved bits all-0 and all-1
    for (int v = 0; v < 4; v++) begin
      for (int p = 0; p < 2; p++) begin
        logic [31:0] d;
        d = (p != 0) ? 32'hFFFE_FFFE : 32'h0;
        d[16] = v[1]; d[0] = v[0];
        doWrite(CTL_A, d);
        doRead(CTL_A, rd);
        check("R2_R3 ctl", rd, CTL_BASE | (32'(v[1]) << 16) | 32'(v[0]));
      end
    end

    // R4 setup clears both stalls
    doWrite(CTL_A, 32'h0001_0001);
    setupSeen = 1'b1; @(negedge clk); setupSeen = 1'b0;
    doRead(CTL_A, rd); check("R4 setup clear", rd, CTL_BASE);
    // R4 setup wins over same-cycle write of 1
    setupSeen = 1'b1;
    doWrite(CTL_A, 32'h0001_0001);
    setupSeen = 1'b0;
    doRead(CTL_A, rd); check("R4 setup wins", rd, CTL_BASE);

    // R9 unmapped address
    doWrite(BAD_A, 32'hFFFF_FFFF);
    doRead(BAD_A, rd); check("R9 unmapped read", rd, 32'h0);
    doRead(CTL_A, rd); check("R9 unmapped write ctl", rd, CTL_BASE);
    doRead(EVT_A, rd); check("R9 unmapped write evt", rd, 32'h0);

    // R5 / R6 / R8 sweep over completion mask and ioc mask
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 16; c++) begin
        doWrite(EVT_A, 32'hF);
        pulseRx(4'(m), 4'(c));
        check("R8 irq on set", {31'b0, irqOut}, {31'b0, |(4'(m) & 4'(c))});
        doRead(EVT_A, rd); check("R5 evt set", rd, 32'(m));
        doWrite(EVT_A, 32'hFFFF_FFF0);
        doRead(EVT_A, rd); check("R6 write0 keeps", rd, 32'(m));
        rem = 4'(m);
        for (int b = 0; b < 4; b++) begin
          doWrite(EVT_A, 32'(1) << b);
          rem[b] = 1'b0;
          check("R8 irq after clear", {31'b0, irqOut}, {31'b0, |(rem & 4'(c))});
          doRead(EVT_A, rd); check("R6 w1c", rd, 32'(rem));
        end
      end
    end

    // R7 set wins over same-cycle clear; other bit clears normally
    pulseRx(4'h6, 4'h0);
    rxDone = 4'h4; rxIoc = 4'h4;
    doWrite(EVT_A, 32'h6);
    rxDone = '0; rxIoc = '0;
    check("R7 irq", {31'b0, irqOut}, 32'h1);
    doRead(EVT_A, rd); check("R7 set wins", rd, 32'h4);
    doWrite(EVT_A, 32'h4);
    check("R8 irq cleared", {31'b0, irqOut}, 32'h0);

    // R9 event writes leave stalls alone, ctl writes leave events alone
    doWrite(CTL_A, 32'h0001_0001);
    pulseRx(4'hA, 4'h0);
    doWrite(EVT_A, 32'hF);
    doRead(CTL_A, rd); check("R9 ctl isolated", rd, CTL_BASE | 32'h0001_0001);
    pulseRx(4'h5, 4'h0);
    doWrite(CTL_A, 32'hFFFF_FFFF);
    doRead(EVT_A, rd); check("R9 evt isolated", rd, 32'h5);
    check("R8 no ioc no irq", {31'b0, irqOut}, 32'h0);

    finish();
  end
endmodule